// File: doc/BRIEF.md
# Clocked and Asynchronous Byte Serial Port

This block moves one byte at a time over a serial line. The byte can go out in a clocked mode, where the serial clock either comes from the block or arrives from a partner device. It can also go out in a half-duplex start/stop mode, where each frame is a low start bit, eight data bits and a high stop bit. One shift register and one bit-period counter serve both modes. All timing is counted in system cycles, which are marked by a clock enable. A single divider value sets the bit period for both modes.

The host loads the transmit byte, selects the mode and strobes `start`. While a frame is in progress `busy` is high. When the frame ends, `done` rises and the received byte appears on `rx_data`. In the clocked mode, data is launched on each falling clock edge and captured on each rising edge, least significant bit first. The data lines can be wired in two ways. In 3-wire wiring there is a separate input line. In 2-wire wiring one shared data line is either driven or listened to. In the start/stop mode the receiver waits for a falling edge, checks the start bit at mid-bit and samples every data bit at mid-bit. It reports a framing error when the stop bit reads low.

Top module: `serport`

## Requirements
- R1: After reset `busy`, `done` and `frame_err` are 0, `rx_data` is 0, and both `sck_out` and `sd_out` are 1.
- R2: A `start` strobe while `busy` is 0 is accepted. In the next cycle `busy` is 1 and `done` and `frame_err` are 0. `busy` and `done` are never 1 together.
- R3: A `start` strobe while `busy` is 1 is ignored. The frame in progress keeps its data and its timing, and a new `tx_data` value presented then is not sent.
- R4: In clocked master mode (`cfg_async`=0, `cfg_master`=1), `sck_out` idles at 1. For each of 8 bits it is low for `cfg_div`+1 system cycles and then high for `cfg_div`+1 system cycles. `done` rises at the end of the eighth high half, which gives a period of 2 to 512 cycles.
- R5: In clocked mode, transmit bits leave least significant bit first and change on the falling edge of the serial clock. Receive bits are captured on the rising edge, into positions 0 to 7 in arrival order. When `done` rises, `rx_data` holds the captured byte.
- R6: In 3-wire wiring (`cfg_3wire`=1), `sd_oe` is 1 and clocked reception uses `si_in`. In 2-wire wiring, `sd_oe` equals `cfg_dir_tx` and clocked reception uses `sd_in`. In start/stop mode, `sd_oe` equals `cfg_dir_tx` and reception uses `si_in`.
- R7: In clocked slave mode (`cfg_master`=0), `sck_oe` is 0 and `sck_out` stays 1. The clock is taken from `sck_in` through a 2-stage synchronizer. `done` rises after the eighth rising edge.
- R8: In start/stop transmit (`cfg_async`=1, `cfg_dir_tx`=1), `sd_out` sends a 0 start bit, then the 8 data bits least significant bit first, then a 1 stop bit. Each bit lasts 8×(`cfg_div`+1) system cycles, a range of 8 to 2048. `done` rises as the stop bit ends.
- R9: In start/stop receive (`cfg_dir_tx`=0), a falling edge on `si_in` starts a frame. The line is checked half a bit later. If it is high again, the frame is dropped and the receiver goes back to waiting. Otherwise each data bit is sampled at its middle, least significant bit first.
- R10: If the stop bit samples low, `frame_err` is 1 when `done` rises. An accepted `start` clears it.
- R11: Bit periods are counted only in cycles where `cyc_en` is 1. With `cyc_en` high every second cycle, each bit lasts twice as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | System-cycle enable for all bit timing |
| cfg_async | input | 1 | 1: start/stop mode, 0: clocked mode |
| cfg_master | input | 1 | Clocked mode: 1 drives the clock, 0 follows `sck_in` |
| cfg_3wire | input | 1 | Clocked mode: 1 separate input line, 0 shared data line |
| cfg_dir_tx | input | 1 | Shared-line and start/stop direction: 1 transmit, 0 receive |
| cfg_div | input | 8 | Bit-period divider value |
| start | input | 1 | Begin a frame (single-cycle strobe) |
| tx_data | input | 8 | Byte to send |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Last frame finished; cleared by an accepted start |
| frame_err | output | 1 | Last received stop bit was low |
| rx_data | output | 8 | Last received byte |
| sck_in | input | 1 | Serial clock from a partner device |
| sck_out | output | 1 | Serial clock driven by this block |
| sck_oe | output | 1 | Output enable for `sck_out` |
| sd_in | input | 1 | Read-back of the shared data line |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for `sd_out` |
| si_in | input | 1 | Separate serial data input |

## Verification
Clocked master transfers are swept over every transmit byte at the smallest divider, using a partner byte that differs from the transmit byte. This separates bit-order and capture-edge faults from plain loopback. Further transfers at larger dividers, up to the maximum, measure every half period. The 2-wire runs drive a decoy pattern on the line that is not used, which shows that the correct input is the one read. Start/stop frames are run at several dividers and at half-rate enable, with one frame that has a low stop bit, one preceded by a short glitch on the line, and one with a `start` strobe injected mid-frame. These runs separate framing, false-start and ignored-strobe behaviour. Slave transfers use two external clock rates to exercise the synchronized edge path.

// File: rtl/serport_pkg.sv
package serport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SM_LOW,
        ST_SM_HIGH,
        ST_SLAVE,
        ST_ATX,
        ST_ARX_HUNT,
        ST_ARX_BIT
    } eng_state_e;

    typedef enum logic [1:0] {
        RL_HALF,
        RL_BIT,
        RL_MID
    } reload_e;

    localparam int OVS_LOG2 = 3;

endpackage

// File: rtl/serport_sync2.sv
module serport_sync2 #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            stg_d[i] = (i == 0) ? din : stg_q[(i == 0) ? 0 : i - 1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/serport_timer.sv
module serport_timer
    import serport_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic [DIV_W-1:0] div,
    input  logic             load,
    input  reload_e          kind,
    output logic             expire
);
    localparam int CNT_W = DIV_W + OVS_LOG2;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] rl_val;

    always_comb begin
        unique case (kind)
            RL_BIT:  rl_val = {div, {OVS_LOG2{1'b1}}};
            RL_MID:  rl_val = {1'b0, div, {(OVS_LOG2-1){1'b1}}};
            default: rl_val = CNT_W'(div);
        endcase
        cnt_d = cnt_q;
        if (load)                          cnt_d = rl_val;
        else if (cyc_en && cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = cyc_en && (cnt_q == '0);
endmodule

// File: rtl/serport_engine.sv
module serport_engine
    import serport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              cfg_async,
    input  logic              cfg_master,
    input  logic              cfg_dir_tx,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_raw,
    input  logic              rx_sync,
    input  logic              sck_sync,
    input  logic              tmr_expire,
    output logic              tmr_load,
    output reload_e           tmr_kind,
    output logic [DATA_W-1:0] rx_data,
    output logic              done,
    output logic              busy,
    output logic              frame_err,
    output logic              sck_out,
    output logic              line_out
);
    localparam int BIT_W = $clog2(DATA_W + 2);
    localparam logic [BIT_W-1:0] NB_LAST = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0] NB_STOP = BIT_W'(DATA_W + 1);

    typedef struct packed {
        eng_state_e        st;
        logic [DATA_W-1:0] sh;
        logic [BIT_W-1:0]  nb;
        logic              sck;
        logic              line;
        logic [DATA_W-1:0] rxd;
        logic              done;
        logic              busy;
        logic              ferr;
        logic              sck_prev;
        logic              rx_prev;
    } eng_regs_t;

    eng_regs_t d, q;
    logic sck_fall, sck_rise, rx_fall;

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_kind = RL_HALF;
        sck_fall = cyc_en && q.sck_prev && !sck_sync;
        sck_rise = cyc_en && !q.sck_prev && sck_sync;
        rx_fall  = cyc_en && q.rx_prev && !rx_sync;
        if (cyc_en) begin
            d.sck_prev = sck_sync;
            d.rx_prev  = rx_sync;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.busy = 1'b1;
                    d.done = 1'b0;
                    d.ferr = 1'b0;
                    d.sh   = tx_data;
                    d.nb   = '0;
                    if (cfg_async) begin
                        if (cfg_dir_tx) begin
                            d.st     = ST_ATX;
                            d.line   = 1'b0;
                            tmr_load = 1'b1;
                            tmr_kind = RL_BIT;
                        end else begin
                            d.st = ST_ARX_HUNT;
                        end
                    end else if (cfg_master) begin
                        d.st     = ST_SM_LOW;
                        d.sck    = 1'b0;
                        d.line   = tx_data[0];
                        tmr_load = 1'b1;
                    end else begin
                        d.st = ST_SLAVE;
                    end
                end
            end

            ST_SM_LOW: begin
                if (tmr_expire) begin
                    d.sck    = 1'b1;
                    d.sh     = {rx_raw, q.sh[DATA_W-1:1]};
                    d.nb     = q.nb + BIT_W'(1);
                    d.st     = ST_SM_HIGH;
                    tmr_load = 1'b1;
                end
            end

            ST_SM_HIGH: begin
                if (tmr_expire) begin
                    if (q.nb == NB_LAST) begin
                        d.rxd  = q.sh;
                        d.done = 1'b1;
                        d.busy = 1'b0;
                        d.line = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.sck    = 1'b0;
                        d.line   = q.sh[0];
                        d.st     = ST_SM_LOW;
                        tmr_load = 1'b1;
                    end
                end
            end

            ST_SLAVE: begin
                if (sck_fall) begin
                    d.line = q.sh[0];
                end
                if (sck_rise) begin
                    d.sh = {rx_sync, q.sh[DATA_W-1:1]};
                    d.nb = q.nb + BIT_W'(1);
                    if (q.nb == NB_LAST - BIT_W'(1)) begin
                        d.rxd  = {rx_sync, q.sh[DATA_W-1:1]};
                        d.done = 1'b1;
                        d.busy = 1'b0;
                        d.line = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end

            ST_ATX: begin
                if (tmr_expire) begin
                    if (q.nb == NB_STOP) begin
                        d.done = 1'b1;
                        d.busy = 1'b0;
                        d.line = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.nb     = q.nb + BIT_W'(1);
                        tmr_load = 1'b1;
                        tmr_kind = RL_BIT;
                        if (q.nb < NB_LAST) begin
                            d.line = q.sh[0];
                            d.sh   = {1'b0, q.sh[DATA_W-1:1]};
                        end else begin
                            d.line = 1'b1;
                        end
                    end
                end
            end

            ST_ARX_HUNT: begin
                if (rx_fall) begin
                    d.st     = ST_ARX_BIT;
                    d.nb     = '0;
                    tmr_load = 1'b1;
                    tmr_kind = RL_MID;
                end
            end

            ST_ARX_BIT: begin
                if (tmr_expire) begin
                    if (q.nb == '0) begin
                        if (rx_sync) begin
                            d.st = ST_ARX_HUNT;
                        end else begin
                            d.nb     = BIT_W'(1);
                            tmr_load = 1'b1;
                            tmr_kind = RL_BIT;
                        end
                    end else if (q.nb <= NB_LAST) begin
                        d.sh     = {rx_sync, q.sh[DATA_W-1:1]};
                        d.nb     = q.nb + BIT_W'(1);
                        tmr_load = 1'b1;
                        tmr_kind = RL_BIT;
                    end else begin
                        d.rxd  = q.sh;
                        d.ferr = !rx_sync;
                        d.done = 1'b1;
                        d.busy = 1'b0;
                        d.st   = ST_IDLE;
                    end
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.sh       <= '0;
            q.nb       <= '0;
            q.sck      <= 1'b1;
            q.line     <= 1'b1;
            q.rxd      <= '0;
            q.done     <= 1'b0;
            q.busy     <= 1'b0;
            q.ferr     <= 1'b0;
            q.sck_prev <= 1'b1;
            q.rx_prev  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data   = q.rxd;
    assign done      = q.done;
    assign busy      = q.busy;
    assign frame_err = q.ferr;
    assign sck_out   = q.sck;
    assign line_out  = q.line;
endmodule

// File: rtl/serport.sv
module serport
    import serport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              cfg_async,
    input  logic              cfg_master,
    input  logic              cfg_3wire,
    input  logic              cfg_dir_tx,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              done,
    output logic              frame_err,
    output logic [DATA_W-1:0] rx_data,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              si_in
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_raw, pins_sync;
    logic             use_shared;
    logic             rx_raw, rx_sync;
    logic             tmr_load, tmr_expire;
    reload_e          tmr_kind;

    assign pins_raw   = {sck_in, sd_in, si_in};
    assign use_shared = !cfg_async && !cfg_3wire;
    assign rx_raw     = use_shared ? sd_in : si_in;
    assign rx_sync    = use_shared ? pins_sync[1] : pins_sync[0];

    serport_sync2 #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    serport_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cyc_en(cyc_en),
        .div   (cfg_div),
        .load  (tmr_load),
        .kind  (tmr_kind),
        .expire(tmr_expire)
    );

    serport_engine #(
        .DATA_W(DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .cfg_async (cfg_async),
        .cfg_master(cfg_master),
        .cfg_dir_tx(cfg_dir_tx),
        .start     (start),
        .tx_data   (tx_data),
        .rx_raw    (rx_raw),
        .rx_sync   (rx_sync),
        .sck_sync  (pins_sync[2]),
        .tmr_expire(tmr_expire),
        .tmr_load  (tmr_load),
        .tmr_kind  (tmr_kind),
        .rx_data   (rx_data),
        .done      (done),
        .busy      (busy),
        .frame_err (frame_err),
        .sck_out   (sck_out),
        .line_out  (sd_out)
    );

    assign sck_oe = !cfg_async && cfg_master;
    assign sd_oe  = cfg_async ? cfg_dir_tx : (cfg_3wire || cfg_dir_tx);
endmodule

// File: rtl/serport_chk.sv
module serport_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_async,
    input logic cfg_master,
    input logic cfg_dir_tx,
    input logic start,
    input logic busy,
    input logic done,
    input logic frame_err,
    input logic sck_out,
    input logic sd_out
);
    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_out && sd_out)); // R1

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done && !frame_err)); // R2

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R2

    AST_MASTER_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cfg_async && cfg_master) |=> !sck_out); // R4

    AST_SLAVE_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cfg_async || !cfg_master)) |-> sck_out); // R7

    AST_ATX_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cfg_async && cfg_dir_tx) |=> !sd_out); // R8

    AST_FERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> (done && cfg_async)); // R10
endmodule

bind serport serport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_async (cfg_async),
    .cfg_master(cfg_master),
    .cfg_dir_tx(cfg_dir_tx),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .frame_err (frame_err),
    .sck_out   (sck_out),
    .sd_out    (sd_out)
);

// File: tb/serport_test.sv
`timescale 1ns/1ps
module serport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b1;
    logic       cfg_async = 1'b0, cfg_master = 1'b1, cfg_3wire = 1'b1, cfg_dir_tx = 1'b1;
    logic [7:0] cfg_div = '0;
    logic       start = 1'b0;
    logic [7:0] tx_data = '0;
    logic       busy, done, frame_err, sck_out, sck_oe, sd_out, sd_oe;
    logic [7:0] rx_data;
    logic       sck_in = 1'b1, sd_in = 1'b1, si_in = 1'b1;
    bit         halfrate = 1'b0;
    int         n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    always @(negedge clk) cyc_en <= halfrate ? ~cyc_en : 1'b1;

    serport uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cfg_async(cfg_async),
        .cfg_master(cfg_master), .cfg_3wire(cfg_3wire), .cfg_dir_tx(cfg_dir_tx),
        .cfg_div(cfg_div), .start(start), .tx_data(tx_data), .busy(busy),
        .done(done), .frame_err(frame_err), .rx_data(rx_data), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sd_in(sd_in), .sd_out(sd_out),
        .sd_oe(sd_oe), .si_in(si_in)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic sm_xfer(input logic [7:0] txb, input logic [7:0] slb, input int div,
                           input bit three, input bit dtx);
        logic [7:0] cap = '0;
        int len = 0, bitc = 0, bad = 0, guard = 0;
        bit prev = 1'b1, now;
        halfrate = 1'b0; cfg_async = 1'b0; cfg_master = 1'b1; cfg_3wire = three;
        cfg_dir_tx = dtx; cfg_div = div[7:0]; tx_data = txb; si_in = 1'b1; sd_in = 1'b1;
        pulse_start();
        while (!done && guard < 5000) begin
            now = sck_out;
            if (prev && !now) begin
                if (bitc > 0 && len != div + 1) bad++;
                len = 0;
                if (bitc < 8) begin
                    if (three) begin si_in = slb[bitc]; sd_in = ~slb[bitc]; end
                    else       begin sd_in = slb[bitc]; si_in = ~slb[bitc]; end
                end
            end else if (!prev && now) begin
                if (len != div + 1) bad++;
                len = 0;
                if (bitc < 8) cap[bitc] = sd_out;
                bitc++;
            end
            prev = now;
            @(negedge clk); len++; guard++;
        end
        chk("R4", "half periods off", bad, 0);
        chk("R4", "rising edges", bitc, 8);
        chk("R4", "last high half", len, div + 1);
        chk("R5", "master rx byte", rx_data, slb);
        if (three || dtx) chk("R5", "master tx byte", cap, txb);
        chk("R6", "sd_oe", sd_oe, three | dtx);
        chk("R4", "sck_oe", sck_oe, 1);
    endtask

    task automatic ss_xfer(input logic [7:0] txb, input logic [7:0] slb, input int h);
        logic [7:0] cap = '0;
        int quiet = 0;
        halfrate = 1'b0; cfg_async = 1'b0; cfg_master = 1'b0; cfg_3wire = 1'b1;
        cfg_dir_tx = 1'b1; tx_data = txb; si_in = 1'b1; sck_in = 1'b1;
        pulse_start();
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; si_in = slb[i];
            repeat (h) begin @(negedge clk); if (!sck_out || sck_oe) quiet++; end
            cap[i] = sd_out;
            sck_in = 1'b1;
            repeat (h) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk("R7", "slave done", done, 1);
        chk("R7", "slave clock quiet", quiet, 0);
        chk("R5", "slave rx byte", rx_data, slb);
        chk("R5", "slave tx byte", cap, txb);
    endtask

    task automatic atx(input logic [7:0] txb, input int div, input bit half, input bit poke);
        int b = 8 * (div + 1) * (half ? 2 : 1);
        logic [9:0] got;
        halfrate = half; cfg_async = 1'b1; cfg_dir_tx = 1'b1; cfg_div = div[7:0]; tx_data = txb;
        repeat (2) @(negedge clk);
        pulse_start();
        repeat (b / 2) @(negedge clk);
        got[0] = sd_out;
        if (poke) begin
            tx_data = ~txb; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int k = 1; k < 10; k++) begin
            repeat ((k == 1 && poke) ? b - 1 : b) @(negedge clk);
            got[k] = sd_out;
        end
        chk("R8", "start bit", got[0], 0);
        chk(poke ? "R3" : "R8", "data bits", got[8:1], txb);
        chk("R8", "stop bit", got[9], 1);
        chk("R6", "sd_oe tx", sd_oe, 1);
        if (!half) begin
            repeat (b / 2 - 1) @(negedge clk);
            chk(poke ? "R3" : "R8", "done before stop end", done, 0);
            @(negedge clk);
            chk(poke ? "R3" : "R8", "done at stop end", done, 1);
        end else begin
            repeat (b / 2 + 4) @(negedge clk);
            chk("R11", "done half rate", done, 1);
        end
        halfrate = 1'b0;
    endtask

    task automatic arx(input logic [7:0] byt, input bit stopv, input int div, input bit glitch);
        int b = 8 * (div + 1);
        halfrate = 1'b0; cfg_async = 1'b1; cfg_dir_tx = 1'b0; cfg_div = div[7:0];
        si_in = 1'b1; sd_in = 1'b0;
        pulse_start();
        chk("R10", "frame_err cleared by start", frame_err, 0);
        chk("R6", "sd_oe rx", sd_oe, 0);
        repeat (3) @(negedge clk);
        if (glitch) begin
            si_in = 1'b0; repeat (2) @(negedge clk);
            si_in = 1'b1; repeat (b) @(negedge clk);
            chk("R9", "still waiting after glitch", {busy, done}, 2'b10);
        end
        si_in = 1'b0; repeat (b) @(negedge clk);
        for (int i = 0; i < 8; i++) begin si_in = byt[i]; repeat (b) @(negedge clk); end
        si_in = stopv; repeat (b) @(negedge clk);
        si_in = 1'b1; repeat (4) @(negedge clk);
        chk("R9", "rx done", {busy, done}, 2'b01);
        chk("R9", "rx byte", rx_data, byt);
        chk("R10", "frame_err", frame_err, !stopv);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1-watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "rx_data", rx_data, 0);
        chk("R1", "sck_out", sck_out, 1);
        chk("R1", "sd_out", sd_out, 1);

        cfg_async = 1'b1; cfg_dir_tx = 1'b1; tx_data = 8'h3C;
        pulse_start();
        chk("R2", "busy after start", busy, 1);
        chk("R2", "done after start", done, 0);
        repeat (90) @(negedge clk);

        for (int v = 0; v < 256; v++)
            sm_xfer(v[7:0], 8'(v * 37 + 11) ^ 8'hC3, 0, 1'b1, 1'b1);
        sm_xfer(8'hA5, 8'h3C, 1, 1'b1, 1'b1);
        sm_xfer(8'h01, 8'h80, 2, 1'b1, 1'b1);
        sm_xfer(8'h7E, 8'hE7, 7, 1'b1, 1'b1);
        sm_xfer(8'h81, 8'h18, 255, 1'b1, 1'b1);
        sm_xfer(8'h96, 8'h71, 1, 1'b0, 1'b0);
        sm_xfer(8'h4D, 8'hB2, 0, 1'b0, 1'b1);

        for (int v = 0; v < 16; v++)
            ss_xfer(8'(v * 29 + 5), 8'(v * 53 + 90), (v % 2 == 0) ? 4 : 6);

        atx(8'h00, 0, 1'b0, 1'b0);
        atx(8'hFF, 0, 1'b0, 1'b0);
        atx(8'hA6, 1, 1'b0, 1'b0);
        atx(8'h5B, 3, 1'b0, 1'b1);
        atx(8'hC9, 1, 1'b1, 1'b0);
        atx(8'h2D, 255, 1'b0, 1'b0);

        arx(8'h5A, 1'b1, 0, 1'b0);
        arx(8'h81, 1'b1, 1, 1'b1);
        arx(8'hE3, 1'b0, 1, 1'b0);
        arx(8'h17, 1'b1, 2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule